// File: doc/BRIEF.md
# Four-Phase FSK Symbol Deinterleaver

This block takes the data symbols of a paging frame and spreads them over four parallel bit phases, called A, B, C and D. Each symbol is a 4-level FSK value from 0 to 3 and arrives with a one-cycle strobe. The frame's mode is given by two static inputs: the symbol rate (1600 or 3200 baud) and the level count (2 or 4). Phases that the current mode does not carry stay at zero, which downstream logic treats as idle.

At 1600 baud every symbol produces one output vector. At 3200 baud, symbols alternate between the A/B pair and the C/D pair. One output vector is produced for every two symbols, and it carries all four bits.

The frame boundary inputs clear the pair selector and all phase bits. The next frame therefore always starts on the A/B pair.

Top module: `fsk_phase_deint`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `phase_o` is 4'b0000 and `phase_valid_o` is 0.
- R2: The first bit of a pair (A, or C for the second pair) is 1 exactly when the symbol value is 0 or 1, that is, below 2. The vector layout is `phase_o[0]`=A, `[1]`=B, `[2]`=C, `[3]`=D.
- R3: With `four_level_i`=1, the second bit of a pair (B or D) is 1 exactly when the symbol is 0 or 3. This gives the Gray mapping 0→(1,1), 1→(1,0), 2→(0,0), 3→(0,1) for (first, second).
- R4: With `four_level_i`=0, B and D are 0 in every output vector.
- R5: With `fast_rate_i`=0 (1600 baud), every accepted symbol produces one output vector with new A/B values, and C and D are 0.
- R6: With `fast_rate_i`=1 (3200 baud), the first symbol after a clear loads A/B and produces no output. The next symbol loads C/D and produces one vector holding all four bits. The two roles then keep alternating.
- R7: `phase_valid_o` is high for exactly one cycle, in the cycle after the strobe of the symbol that completes a vector. It is never high at any other time.
- R8: A high `frame_start_i` or `frame_done_i` clears the pair selector, all phase bits and `phase_o` on the next edge. A symbol strobed in the same cycle is ignored.
- R9: A 3200-baud, 4-level frame of 5632 back-to-back symbols yields exactly 2816 output vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Clears state at the start of a frame |
| frame_done_i | input | 1 | Clears state at the end of a frame |
| sym_valid_i | input | 1 | Symbol strobe |
| sym_i | input | 2 | 4-level FSK symbol value 0..3 |
| fast_rate_i | input | 1 | 1 = 3200 baud, alternate pairs; 0 = 1600 baud |
| four_level_i | input | 1 | 1 = 4-level (B/D used); 0 = 2-level |
| phase_o | output | 4 | Phase vector {D,C,B,A} |
| phase_valid_o | output | 1 | One-cycle pulse when phase_o is new |

## Verification
Some properties are checked on every cycle:
- A valid pulse always follows an accepted strobe.
- Under 2-level or 1600-baud operation, the unused phases are zero.
- The first bit of each pair and the Gray relation of the second bit match the symbol that completed the vector.
- A clear empties the output.
- The first half of a 3200-baud pair never emits.

Other behaviour can only be shown by the bench's scenarios:
- The pairing of two specific symbols into one vector.
- Realignment to A/B after a mid-pair clear.
- The exact count of 2816 vectors over a full-length frame.

// File: rtl/fsk_deint_pkg.sv
package fsk_deint_pkg;
  localparam int SYM_W   = 2;
  localparam int PAIR_W  = 2;
  localparam int NPAIRS  = 2;
  localparam int PHASE_W = PAIR_W * NPAIRS;

  typedef logic [SYM_W-1:0]   sym_t;
  typedef logic [PAIR_W-1:0]  pair_t;   // [0] first bit, [1] second bit
  typedef logic [PHASE_W-1:0] phase_t;  // {D,C,B,A}
endpackage

// File: rtl/fsk_dibit_slicer.sv
module fsk_dibit_slicer
  import fsk_deint_pkg::*;
(
  input  sym_t  sym_i,
  input  logic  four_level_i,
  output pair_t pair_o
);
  logic low_half;
  logic gray_second;

  always_comb begin
    low_half    = (sym_i < sym_t'(2));
    gray_second = (sym_i == sym_t'(0)) || (sym_i == sym_t'(3));
    pair_o[0]   = low_half;
    pair_o[1]   = four_level_i ? gray_second : 1'b0;
  end
endmodule

// File: rtl/fsk_pair_sequencer.sv
module fsk_pair_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic sym_valid_i,
  input  logic fast_rate_i,
  output logic upper_sel_o,
  output logic complete_o
);
  logic sel_q, sel_d;
  logic sel_en;

  always_comb begin
    sel_en = clear_i || sym_valid_i;
    sel_d  = sel_q;
    if (clear_i)
      sel_d = 1'b0;
    else if (sym_valid_i)
      sel_d = fast_rate_i ? ~sel_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= 1'b0;
    else if (sel_en)
      sel_q <= sel_d;
  end

  assign upper_sel_o = fast_rate_i & sel_q;
  assign complete_o  = sym_valid_i & ~clear_i & (~fast_rate_i | sel_q);
endmodule

// File: rtl/fsk_phase_regs.sv
module fsk_phase_regs
  import fsk_deint_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear_i,
  input  logic   sym_valid_i,
  input  logic   fast_rate_i,
  input  logic   upper_sel_i,
  input  logic   complete_i,
  input  pair_t  pair_i,
  output phase_t phase_o,
  output logic   valid_o
);
  pair_t  lo_q, lo_d, hi_q, hi_d;
  phase_t out_q, out_d;
  logic   vld_q, vld_d;
  logic   state_en;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    out_d    = out_q;
    vld_d    = 1'b0;
    state_en = clear_i || sym_valid_i;
    if (clear_i) begin
      lo_d  = '0;
      hi_d  = '0;
      out_d = '0;
    end else if (sym_valid_i) begin
      if (upper_sel_i) hi_d = pair_i;
      else             lo_d = pair_i;
      if (complete_i) begin
        if (fast_rate_i) out_d = {pair_i, lo_q};
        else             out_d = {pair_t'(0), pair_i};
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      out_q <= '0;
    end else if (state_en) begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign phase_o = out_q;
  assign valid_o = vld_q;

  // R8: clear empties the output on the next edge
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (out_q == '0 && !vld_q));
endmodule

// File: rtl/fsk_phase_deint.sv
module fsk_phase_deint
  import fsk_deint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic             frame_done_i,
  input  logic             sym_valid_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             fast_rate_i,
  input  logic             four_level_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic             phase_valid_o
);
  logic  clear;
  logic  upper_sel;
  logic  complete;
  pair_t pair;

  assign clear = frame_start_i | frame_done_i;

  fsk_dibit_slicer u_slicer (
    .sym_i        (sym_i),
    .four_level_i (four_level_i),
    .pair_o       (pair)
  );

  fsk_pair_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear),
    .sym_valid_i (sym_valid_i),
    .fast_rate_i (fast_rate_i),
    .upper_sel_o (upper_sel),
    .complete_o  (complete)
  );

  fsk_phase_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear),
    .sym_valid_i (sym_valid_i),
    .fast_rate_i (fast_rate_i),
    .upper_sel_i (upper_sel),
    .complete_i  (complete),
    .pair_i      (pair),
    .phase_o     (phase_o),
    .valid_o     (phase_valid_o)
  );

  // R7: a valid pulse only follows an accepted strobe
  assert_valid_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid_o |-> $past(sym_valid_i && !clear));

  // R6: the first half of a fast pair never emits
  assert_first_half_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_i && !clear && fast_rate_i && !upper_sel) |=> !phase_valid_o);

  // R4: 2-level keeps B and D at zero
  assert_two_level_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid_o && !$past(four_level_i)) |-> (phase_o[1] == 1'b0 && phase_o[3] == 1'b0));

  // R5: slow rate keeps C and D at zero
  assert_slow_upper_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid_o && !$past(fast_rate_i)) |-> (phase_o[3:2] == 2'b00));

  // R2: first bit of the completing pair reflects symbol below 2
  assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid_o |-> (($past(fast_rate_i) ? phase_o[2] : phase_o[0]) == !$past(sym_i[1])));

  // R3: Gray relation, second bit equals first bit xor symbol LSB
  assert_gray_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid_o && $past(four_level_i)) |->
      (($past(fast_rate_i) ? phase_o[3] ^ phase_o[2] : phase_o[1] ^ phase_o[0]) == $past(sym_i[0])));
endmodule

// File: tb/tb_fsk_phase_deint.sv
module tb_fsk_phase_deint;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start_i = 1'b0;
  logic       frame_done_i = 1'b0;
  logic       sym_valid_i = 1'b0;
  logic [1:0] sym_i = 2'd0;
  logic       fast_rate_i = 1'b0;
  logic       four_level_i = 1'b0;
  logic [3:0] phase_o;
  logic       phase_valid_o;

  int checks = 0;
  int errors = 0;
  int out_count = 0;
  bit done = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  bit         m_tog = 0;
  logic       m_a = 0, m_b = 0;

  always #2 clk = ~clk;

  fsk_phase_deint dut (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i), .frame_done_i(frame_done_i),
    .sym_valid_i(sym_valid_i), .sym_i(sym_i), .fast_rate_i(fast_rate_i),
    .four_level_i(four_level_i), .phase_o(phase_o), .phase_valid_o(phase_valid_o)
  );

  function automatic logic first_bit(input logic [1:0] s);
    return (s == 2'd0) || (s == 2'd1);
  endfunction

  function automatic logic second_bit(input logic [1:0] s, input logic four);
    if (!four) return 1'b0;
    return (s == 2'd0) || (s == 2'd3);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_sym(input logic [1:0] s, input string tag);
    sym_i = s;
    sym_valid_i = 1'b1;
    if (!fast_rate_i) begin
      exp_q.push_back({2'b00, second_bit(s, four_level_i), first_bit(s)});
      tag_q.push_back(tag);
    end else if (!m_tog) begin
      m_a = first_bit(s);
      m_b = second_bit(s, four_level_i);
      m_tog = 1;
    end else begin
      exp_q.push_back({second_bit(s, four_level_i), first_bit(s), m_b, m_a});
      tag_q.push_back(tag);
      m_tog = 0;
    end
    @(negedge clk);
    sym_valid_i = 1'b0;
  endtask

  task automatic do_clear(input bit use_done, input bit with_sym);
    frame_start_i = !use_done;
    frame_done_i = use_done;
    sym_valid_i = with_sym;
    sym_i = 2'd0;
    m_tog = 0; m_a = 0; m_b = 0;
    @(negedge clk);
    frame_start_i = 1'b0;
    frame_done_i = 1'b0;
    sym_valid_i = 1'b0;
    check(phase_o == 4'h0 && !phase_valid_o, "R8 clear", {phase_valid_o, phase_o}, 0);
  endtask

  // Monitor: compare every produced vector against the scoreboard
  always @(negedge clk) begin
    if (rst_n && phase_valid_o) begin
      out_count++;
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected valid", phase_o, 0);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(phase_o == e, t, phase_o, e);
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(phase_o == 4'h0 && !phase_valid_o, "R1 reset", {phase_valid_o, phase_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase_o == 4'h0 && !phase_valid_o, "R1 after release", {phase_valid_o, phase_o}, 0);

    // R5 R2 R4: slow 2-level, all symbol values
    fast_rate_i = 0; four_level_i = 0;
    for (int s = 0; s < 4; s++) send_sym(2'(s), "R4 slow 2-level");
    // R3 R5: slow 4-level Gray
    four_level_i = 1;
    for (int s = 0; s < 4; s++) send_sym(2'(s), "R3 slow gray");
    // gapped symbols
    for (int s = 3; s >= 0; s--) begin
      send_sym(2'(s), "R5 slow gapped");
      @(negedge clk);
    end
    @(negedge clk);
    check(exp_q.size() == 0, "R5 slow drained", exp_q.size(), 0);

    // R6: fast 4-level pairs, all 16 combinations
    do_clear(0, 0);
    fast_rate_i = 1;
    for (int p = 0; p < 16; p++) begin
      send_sym(2'(p >> 2), "R6 fast first");
      send_sym(2'(p), "R6 fast pair");
    end
    // R6: first half alone produces nothing
    send_sym(2'd2, "R6 half");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0 && !phase_valid_o, "R6 half silent", exp_q.size(), 0);
    // R8: frame done mid-pair with concurrent symbol ignored, realigns to A/B
    do_clear(1, 1);
    send_sym(2'd1, "R8 realign first");
    send_sym(2'd3, "R8 realign pair");
    // R4 R6: fast 2-level
    do_clear(0, 1);
    four_level_i = 0;
    for (int s = 0; s < 8; s++) send_sym(2'(s), "R4 fast 2-level");
    @(negedge clk);

    // R9: full-length fast 4-level frame
    do_clear(0, 0);
    four_level_i = 1;
    out_count = 0;
    for (int i = 0; i < 5632; i++) begin
      sym_i = 2'((i * 7 + i / 5) & 3);
      send_sym(sym_i, "R9 long frame");
    end
    repeat (3) @(negedge clk);
    check(out_count == 2816, "R9 vector count", out_count, 2816);
    check(exp_q.size() == 0, "R9 drained", exp_q.size(), 0);
    do_clear(1, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule